// File: doc/BRIEF.md
# Microwire Serial EEPROM Target

This block is the slave end of a three-wire serial memory link with a chip select. A host raises chip select, clocks in a start bit, a two-bit command, an address and, for stores, a data value. The block answers from a 1 Kbit internal register file. A strap input picks the organization: 64 locations of 16 bits, or 128 locations of 8 bits.

Reads stream data back on the serial output and continue from one location to the next for as long as chip select stays high. Modifying commands are guarded by an enable latch. They do not change the array at once. Instead they start a self-timed programming cycle, whose length in system clock cycles is a parameter. While that cycle runs, the serial output reports busy or ready whenever chip select is high.

All serial inputs are synchronized to the system clock, and their edges are detected in that domain. A synchronous reset stands in for power-on reset.

Top module: `mw_eeprom_target`

## Requirements
- R1: While idle with chip select high, a 0 sampled on a rising serial clock is ignored. The first 1 is the start bit, and the next two bits are the command: 10 read, 01 write, 11 erase. Command 00 is extended by the two most significant address bits: 11 enables modification, 00 disables it, 10 erases all, 01 writes all. The remaining address bits of an extended command are don't-care.
- R2: With org_x16=1 the address is 6 bits and the data is 16 bits. With org_x16=0 the address is 7 bits and the data is 8 bits. Byte 2k is the high byte of word k and byte 2k+1 is its low byte. All bits are sent most significant bit first.
- R3: For a read, the rising clock edge that samples the last address bit drives a single 0 on sdo. Each following rising edge drives the next data bit, most significant bit first.
- R4: While chip select stays high, a read continues with the next location and no further dummy bit. The address wraps from the last location (63 for x16, 127 for x8) to 0.
- R5: The enable latch is clear after reset. Enable sets it and disable clears it. Write, erase, erase-all and write-all leave the array unchanged while the latch is clear. Reads work whatever the latch state.
- R6: A write or write-all starts programming only if chip select falls after the last data bit and before the next rising clock. An extra clock, or a fall before the data is complete, leaves the array unchanged.
- R7: Erase sets every bit of the addressed location to 1. A write replaces the whole location whatever its previous content.
- R8: Erase-all sets every location to all ones. Write-all stores the same data value in every location.
- R9: During programming, sdo is 0 while chip select is high. PROG_CYCLES system cycles after programming starts it ends, and sdo then reads 1 while chip select is high, until the next start bit.
- R10: Every serial command received during programming is ignored.
- R11: After reset, sdo is 0 and the block waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| org_x16 | input | 1 | Organization strap: 1 selects 16-bit locations, 0 selects 8-bit |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, also the busy/ready indicator |

## Verification
Each serial input passes two synchronizer flops and an edge register, so a bit that a rising sck clocks out appears on sdo about three system cycles after that edge. The bench holds each sck phase for six system cycles and samples sdo only at the falling edge of sck. The end of programming comes PROG_CYCLES cycles after the block sees chip select fall. The bench therefore probes busy a few cycles after the fall and probes ready only after the full count plus margin. The array is swept exhaustively in both organizations. Every value read back is compared against a byte model that the bench updates from the requirements.

// File: rtl/mw_eeprom_target.sv
module mw_eeprom_target #(
  parameter int WA          = 6,
  parameter int PROG_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_x16,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo
);
  localparam int BA = WA + 1;
  localparam int NB = 1 << BA;
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int CW = $clog2(((BA > 16) ? BA : 16) + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DIN, S_DOUT, S_ARM, S_DEAD, S_BUSY} st_t;
  typedef enum logic [1:0] {K_WRITE, K_ERASE, K_ERAL, K_WRAL} kind_t;

  logic [7:0]    mem [NB];
  logic [2:0]    cs_q, sck_q, sdi_q;
  st_t           st;
  kind_t         kind;
  logic [1:0]    opc;
  logic [BA-1:0] addr, a_next, a_inc;
  logic [15:0]   din, shreg;
  logic [CW-1:0] bitcnt, last_a, last_d;
  logic [PW-1:0] pcnt;
  logic          sdo_r, wen, rdy;
  logic [1:0]    ext;

  wire cs_s     = cs_q[1];
  wire cs_d     = cs_q[2];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sdi_s    = sdi_q[1];
  wire prog_fire = (st == S_BUSY) && (pcnt == PW'(PROG_CYCLES - 1));

  assign last_a = org_x16 ? CW'(WA - 1) : CW'(WA);
  assign last_d = org_x16 ? CW'(15) : CW'(7);
  assign a_next = {addr[BA-2:0], sdi_s};
  assign ext    = org_x16 ? a_next[WA-1 -: 2] : a_next[BA-1 -: 2];
  assign a_inc  = org_x16 ? {1'b0, addr[WA-1:0] + WA'(1)} : addr + BA'(1);
  assign sdo    = cs_s & (((st == S_DOUT) & sdo_r) | ((st == S_IDLE) & rdy));

  function automatic logic [15:0] rd_word(input logic [BA-1:0] a);
    if (org_x16) return {mem[{a[WA-1:0], 1'b0}], mem[{a[WA-1:0], 1'b1}]};
    else         return {mem[a], 8'h00};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= '0; sck_q <= '0; sdi_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[1:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WRITE; opc <= '0; addr <= '0; din <= '0;
      shreg <= '0; bitcnt <= '0; pcnt <= '0; sdo_r <= 1'b0; wen <= 1'b0; rdy <= 1'b0;
    end else if (st == S_BUSY) begin
      pcnt <= pcnt + PW'(1);
      if (prog_fire) begin
        st  <= S_IDLE;
        rdy <= 1'b1;
      end
    end else if (!cs_s) begin
      if (st == S_ARM && cs_d && wen) begin
        st   <= S_BUSY;
        pcnt <= '0;
      end else begin
        st <= S_IDLE;
      end
    end else if (sck_rise) begin
      case (st)
        S_IDLE: if (sdi_s) begin
          st <= S_OPC; bitcnt <= '0; rdy <= 1'b0; addr <= '0; din <= '0;
        end
        S_OPC: begin
          opc    <= {opc[0], sdi_s};
          bitcnt <= bitcnt + CW'(1);
          if (bitcnt == CW'(1)) begin
            st <= S_ADDR; bitcnt <= '0;
          end
        end
        S_ADDR: begin
          addr   <= a_next;
          bitcnt <= bitcnt + CW'(1);
          if (bitcnt == last_a) begin
            bitcnt <= '0;
            case (opc)
              2'b10: begin st <= S_DOUT; shreg <= rd_word(a_next); sdo_r <= 1'b0; end
              2'b01: begin st <= S_DIN; kind <= K_WRITE; end
              2'b11: begin st <= S_ARM; kind <= K_ERASE; end
              default: case (ext)
                2'b11:   begin wen <= 1'b1; st <= S_DEAD; end
                2'b00:   begin wen <= 1'b0; st <= S_DEAD; end
                2'b10:   begin st <= S_ARM; kind <= K_ERAL; end
                default: begin st <= S_DIN; kind <= K_WRAL; end
              endcase
            endcase
          end
        end
        S_DIN: begin
          din    <= {din[14:0], sdi_s};
          bitcnt <= bitcnt + CW'(1);
          if (bitcnt == last_d) st <= S_ARM;
        end
        S_ARM: if (kind == K_WRITE || kind == K_WRAL) st <= S_DEAD;
        S_DOUT: begin
          sdo_r  <= shreg[15];
          shreg  <= {shreg[14:0], 1'b0};
          bitcnt <= bitcnt + CW'(1);
          if (bitcnt == last_d) begin
            addr   <= a_inc;
            shreg  <= rd_word(a_inc);
            bitcnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  wire [15:0] wdat = (kind == K_ERASE || kind == K_ERAL) ? 16'hFFFF : din;

  always_ff @(posedge clk) begin
    if (prog_fire) begin
      if (kind == K_ERAL || kind == K_WRAL) begin
        for (int i = 0; i < NB; i++)
          mem[i] <= (org_x16 && (i % 2 == 0)) ? wdat[15:8] : wdat[7:0];
      end else if (org_x16) begin
        mem[{addr[WA-1:0], 1'b0}] <= wdat[15:8];
        mem[{addr[WA-1:0], 1'b1}] <= wdat[7:0];
      end else begin
        mem[addr] <= wdat[7:0];
      end
    end
  end

  p_start_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && $past(st) != S_BUSY) |-> ($past(st) == S_ARM && $past(wen)));

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_BUSY && $past(st) == S_BUSY) |-> ($past(pcnt) == PW'(PROG_CYCLES - 1)));

  p_wen_by_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen != $past(wen)) |-> ($past(st) == S_ADDR));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && $past(st) == S_BUSY) |-> ($stable(addr) && $stable(din) && $stable(wen)));

  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DOUT && $past(st) == S_DOUT && addr != $past(addr)) |-> ($past(bitcnt) == $past(last_d)));
endmodule

// File: tb/sim_mw_eeprom_target.sv
module sim_mw_eeprom_target;
  localparam int HP   = 6;
  localparam int PROG = 500;

  logic clk = 1'b0, rst_n = 1'b0, org_x16 = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  int   checks = 0, fails = 0;
  logic [7:0] mdl [128];
  logic wen_m = 1'b0;
  logic qd;

  mw_eeprom_target #(.WA(6), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sck(sck), .sdi(sdi), .sdo(sdo));

  always #5 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int abits(); return org_x16 ? 6 : 7; endfunction
  function automatic int dbits(); return org_x16 ? 16 : 8; endfunction
  function automatic int nloc();  return org_x16 ? 64 : 128; endfunction

  function automatic logic [15:0] mget(input int a);
    if (org_x16) return {mdl[2*a], mdl[2*a+1]};
    else         return {8'h00, mdl[a]};
  endfunction

  task automatic mput(input int a, input logic [15:0] d);
    if (org_x16) begin mdl[2*a] = d[15:8]; mdl[2*a+1] = d[7:0]; end
    else mdl[a] = d[7:0];
  endtask

  task automatic bitx(input logic d, output logic q);
    sdi = d; wait_n(HP);
    sck = 1'b1; wait_n(HP);
    sck = 1'b0; q = sdo;
  endtask

  task automatic sendv(input logic [31:0] v, input int n, output logic q);
    q = 1'b0;
    for (int i = n - 1; i >= 0; i--) bitx(v[i], q);
  endtask

  task automatic hdr(input int lead, input logic [1:0] op, input logic [31:0] a, output logic q);
    cs = 1'b1; wait_n(HP);
    if (lead > 0) sendv(0, lead, q);
    sendv({1'b1, op}, 3, q);
    sendv(a, abits(), q);
  endtask

  task automatic desel();
    cs = 1'b0; wait_n(HP);
  endtask

  task automatic prog_wait(input bit dochk, input string req);
    cs = 1'b0; wait_n(4);
    cs = 1'b1; wait_n(HP);
    if (dochk) chk({req, " busy"}, sdo, 0);
    wait_n(PROG);
    if (dochk) chk({req, " ready"}, sdo, 1);
    desel();
  endtask

  task automatic ext(input logic [1:0] code);
    logic [31:0] a;
    a = (32'(code) << (abits() - 2)) | 32'h5;
    hdr(0, 2'b00, a, qd);
    if (code == 2'b11) wen_m = 1'b1;
    if (code == 2'b00) wen_m = 1'b0;
    if (code == 2'b10) begin
      prog_wait(1, "R8 R9");
      if (wen_m) for (int i = 0; i < 128; i++) mdl[i] = 8'hFF;
    end else desel();
  endtask

  task automatic wral(input logic [15:0] d);
    hdr(0, 2'b00, 32'(2'b01) << (abits() - 2), qd);
    sendv(d, dbits(), qd);
    prog_wait(0, "R8");
    if (wen_m) for (int i = 0; i < 128; i++)
      mdl[i] = (org_x16 && (i % 2 == 0)) ? d[15:8] : d[7:0];
  endtask

  task automatic wr(input int a, input logic [15:0] d, input bit dochk);
    hdr(0, 2'b01, a, qd);
    sendv(d, dbits(), qd);
    prog_wait(dochk, "R6 R9");
    if (wen_m) mput(a, d);
  endtask

  task automatic er(input int a);
    hdr(0, 2'b11, a, qd);
    prog_wait(0, "R7");
    if (wen_m) mput(a, 16'hFFFF);
  endtask

  task automatic rd(input int lead, input int a, input int cnt, input string req);
    logic [15:0] v;
    logic q;
    hdr(lead, 2'b10, a, q);
    chk({req, " R3 dummy"}, q, 0);
    for (int k = 0; k < cnt; k++) begin
      v = '0;
      for (int b = 0; b < dbits(); b++) begin
        bitx(1'b0, q);
        v = {v[14:0], q};
      end
      chk(req, v, mget((a + k) % nloc()));
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    wait_n(5);
    chk("R11 reset sdo", sdo, 0);
    rst_n = 1'b1; wait_n(5);
    cs = 1'b1; wait_n(HP);
    chk("R11 idle sdo", sdo, 0);
    desel();

    org_x16 = 1'b1;
    ext(2'b11);
    ext(2'b10);
    rd(0, 60, 6, "R8 eral");
    ext(2'b00);
    wr(5, 16'h1234, 0);
    er(6);
    rd(0, 5, 1, "R5 write ignored");
    ext(2'b11);
    wr(6, 16'h0000, 0);
    ext(2'b00);
    er(6);
    rd(0, 6, 1, "R5 erase ignored");
    ext(2'b11);

    for (int a = 0; a < 64; a++) wr(a, 16'hA5C3 ^ 16'(a * 16'h0123), a == 0);
    rd(0, 0, 66, "R4 x16 sweep+wrap");

    org_x16 = 1'b0;
    rd(0, 0, 130, "R2 R4 x8 sweep+wrap");
    wr(9, 16'h003C, 0);
    org_x16 = 1'b1;
    rd(0, 4, 1, "R2 byte into word");

    er(10);
    rd(0, 10, 1, "R7 erase");
    wr(10, 16'h0F0F, 0);
    wr(10, 16'h00F0, 0);
    rd(0, 10, 1, "R7 overwrite");

    hdr(0, 2'b01, 11, qd);
    sendv(16'hDEAD, 16, qd);
    bitx(1'b0, qd);
    prog_wait(0, "R6");
    hdr(0, 2'b01, 12, qd);
    sendv(16'hBEEF >> 6, 10, qd);
    prog_wait(0, "R6");
    rd(0, 11, 2, "R6 no start");

    rd(4, 3, 1, "R1 leading zeros");

    wr(20, 16'h1111, 0);
    hdr(0, 2'b01, 21, qd);
    sendv(16'h2222, 16, qd);
    cs = 1'b0; wait_n(4);
    cs = 1'b1; wait_n(HP);
    hdr(0, 2'b01, 22, qd);
    sendv(16'h3333, 16, qd);
    cs = 1'b0; wait_n(PROG);
    mput(21, 16'h2222);
    rd(0, 21, 2, "R10 busy ignore");

    ext(2'b00);
    rd(0, 20, 1, "R5 read with latch clear");
    ext(2'b11);

    org_x16 = 1'b0;
    wral(16'h0096);
    rd(0, 125, 5, "R8 wral x8");
    org_x16 = 1'b1;
    wral(16'hBEEF);
    rd(0, 62, 4, "R8 wral x16");

    summary();
    $finish;
  end
endmodule